// File: doc/BRIEF.md
# ADC Sample/Convert Sequencing Controller

This block times and steers one channel of a 10-bit successive-approximation converter. It holds the sample/hold switch closed while sampling, decides when sampling ends, runs the bit-by-bit approximation against a digital comparator input, and hands over the finished code in a one-cycle pulse. The analog front end (switch, DAC, comparator) sits outside. The block drives the DAC trial code and reads back one comparator bit per conversion-clock period.

Four sources can end sampling and start a conversion: software dropping the sample request, a rising edge on an external trigger pin, a rising edge on a timer-match line, or an internal count of conversion-clock periods. Each conversion spends one conversion-clock period per result bit and then two settle periods. The conversion-clock period is the system clock period times (divider + 1). With automatic restart enabled, the block goes back to sampling as soon as a result is delivered, so a sample/convert loop can run with no software action.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `samp_o`, `done_o` and `result_valid_o` are 0.
- R2: A conversion lasts exactly 12 conversion-clock periods, where one period is (clk_div_i + 1) clock cycles. `result_valid_o` is high for a single cycle, 12*(clk_div_i+1) cycles after the cycle in which `samp_o` fell.
- R3: The code is resolved MSB first, one bit per conversion-clock period. `bit_stb_o` pulses exactly 10 times per conversion and never while sampling. With `cmp_i` = 1 meaning "input at or above `dac_code_o`", `result_o` equals the input value.
- R4: With trigger select 3'b000, a `samp_clr_i` pulse during sampling ends sampling and starts a conversion at the next clock edge.
- R5: With trigger select 3'b001 (external pin) or 3'b010 (timer match), the input passes through two synchronizer flops and only its rising edge counts. If the input is driven high just before edge k, sampling ends at edge k+2. An edge that arrives while not sampling is ignored.
- R6: With trigger select 3'b111, sampling lasts max(samp_ticks_i, 1) conversion-clock periods and then a conversion starts by itself.
- R7: Trigger codes 3'b011 to 3'b110 never start a conversion. With any code other than 3'b000, `samp_clr_i` during sampling returns the block to idle without converting.
- R8: When `auto_samp_i` = 1 at the delivering edge, `samp_o` is 1 in the same cycle as `result_valid_o`. Clearing `auto_samp_i` during a conversion lets that conversion finish, and then the block goes idle.
- R9: `done_o` clears when a conversion starts and sets together with `result_valid_o`. A `done_clr_i` pulse clears it without disturbing a conversion in progress. If both happen at the same edge, the set wins.
- R10: While `en_i` = 0, the block is idle. Dropping `en_i` during a conversion aborts it, and no result is delivered for it.
- R11: `samp_set_i` starts sampling only from idle with `en_i` = 1. A pulse during a conversion or while disabled has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable; low aborts and idles |
| auto_samp_i | input | 1 | Restart sampling after each result |
| samp_set_i | input | 1 | Software pulse: start sampling |
| samp_clr_i | input | 1 | Software pulse: end sampling |
| trig_sel_i | input | 3 | Conversion trigger source select |
| ext_trig_i | input | 1 | Asynchronous external trigger |
| tmr_match_i | input | 1 | Timer-match trigger |
| clk_div_i | input | 8 | Conversion-clock divider minus one |
| samp_ticks_i | input | 5 | Sample length in conversion-clock periods (counter mode) |
| done_clr_i | input | 1 | Software pulse: clear done flag |
| cmp_i | input | 1 | Comparator: input at or above DAC code |
| samp_o | output | 1 | Sample/hold switch closed |
| dac_code_o | output | 10 | Trial code for the DAC |
| bit_stb_o | output | 1 | One result bit resolved this cycle |
| done_o | output | 1 | Done flag |
| result_valid_o | output | 1 | One-cycle result pulse |
| result_o | output | 10 | Converted code |

## Verification
The bench attacks the cycle counts at the seams: a divider of zero where every cycle is a tick, a counter-mode sample length of zero that must behave as one period, and a trigger edge that must land exactly two edges after its first flop. A design that is off by one in the step counter or the synchronizer would deliver results a period or a cycle early or late. It also aborts conversions by dropping the enable, clears done in mid-conversion, pulses triggers while idle, and selects a reserved trigger code. A design that let any of these through would produce a stray result pulse or a missing one, or would leave the switch in the wrong state. Results at code 0, full scale and alternating patterns expose a SAR that misorders or drops bits.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int RES_W_DEF  = 10;
  localparam int SETTLE_DEF = 2;
  localparam int DIV_W_DEF  = 8;
  localparam int SAMP_W_DEF = 5;

  localparam logic [2:0] TRIG_SW  = 3'b000;
  localparam logic [2:0] TRIG_EXT = 3'b001;
  localparam logic [2:0] TRIG_TMR = 3'b010;
  localparam logic [2:0] TRIG_CNT = 3'b111;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SAMP = 2'd1,
    ST_CONV = 2'd2
  } seq_state_e;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], d_i};
  end

  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its delayed copy
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/adc_tick_gen.sv
module adc_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            cnt_q <= '0;
    else if (!run_i || restart_i || tick_o) cnt_q <= '0;
    else                                    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int RES_W  = 10,
  parameter int SETTLE = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             active_i,
  input  logic             tick_i,
  input  logic             cmp_i,
  output logic [RES_W-1:0] code_o,
  output logic             bit_stb_o,
  output logic             last_o
);
  localparam int TOTAL  = RES_W + SETTLE;
  localparam int STEP_W = $clog2(TOTAL + 1);

  logic [STEP_W-1:0] step_q;
  logic [RES_W-1:0]  code_q, code_nx;

  assign bit_stb_o = active_i && tick_i && (step_q < STEP_W'(RES_W));
  assign last_o    = active_i && tick_i && (step_q == STEP_W'(TOTAL - 1));
  assign code_o    = code_q;

  // step s settles bit RES_W-1-s and raises the next lower trial bit
  always_comb begin
    code_nx = code_q;
    for (int i = 1; i < RES_W; i++) begin
      if (step_q == STEP_W'(RES_W - 1 - i)) begin
        code_nx[i]   = cmp_i;
        code_nx[i-1] = 1'b1;
      end
    end
    if (step_q == STEP_W'(RES_W - 1)) code_nx[0] = cmp_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= '0;
      code_q <= '0;
    end else if (start_i) begin
      step_q <= '0;
      code_q <= {1'b1, {(RES_W-1){1'b0}}};
    end else if (active_i && tick_i) begin
      step_q <= step_q + 1'b1;
      if (bit_stb_o) code_q <= code_nx;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int RES_W       = RES_W_DEF,
  parameter int SETTLE      = SETTLE_DEF,
  parameter int DIV_W       = DIV_W_DEF,
  parameter int SAMP_W      = SAMP_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              auto_samp_i,
  input  logic              samp_set_i,
  input  logic              samp_clr_i,
  input  logic [2:0]        trig_sel_i,
  input  logic              ext_trig_i,
  input  logic              tmr_match_i,
  input  logic [DIV_W-1:0]  clk_div_i,
  input  logic [SAMP_W-1:0] samp_ticks_i,
  input  logic              done_clr_i,
  input  logic              cmp_i,
  output logic              samp_o,
  output logic [RES_W-1:0]  dac_code_o,
  output logic              bit_stb_o,
  output logic              done_o,
  output logic              result_valid_o,
  output logic [RES_W-1:0]  result_o
);
  localparam int NSRC = 2;

  seq_state_e state_q, state_d;
  logic in_conv, in_samp, tick, restart, conv_start, trig_fire, cnt_hit;
  logic sar_active, sar_last;
  logic [NSRC-1:0]   trig_raw, trig_rise;
  logic [SAMP_W-1:0] scnt_q;
  logic [SAMP_W:0]   samp_min;
  logic              done_q, valid_q;
  logic [RES_W-1:0]  result_q, sar_code;

  assign in_conv = (state_q == ST_CONV);
  assign in_samp = (state_q == ST_SAMP);

  assign trig_raw = {tmr_match_i, ext_trig_i};
  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    adc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (trig_raw[g]),
      .rise_o (trig_rise[g])
    );
  end

  assign restart = (state_d != state_q);

  adc_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (en_i && (state_q != ST_IDLE)),
    .restart_i (restart),
    .div_i     (clk_div_i),
    .tick_o    (tick)
  );

  assign sar_active = en_i && in_conv;

  adc_sar_engine #(.RES_W(RES_W), .SETTLE(SETTLE)) u_sar (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (conv_start),
    .active_i  (sar_active),
    .tick_i    (tick),
    .cmp_i     (cmp_i),
    .code_o    (sar_code),
    .bit_stb_o (bit_stb_o),
    .last_o    (sar_last)
  );

  // zero sample length behaves as one period
  assign samp_min = (samp_ticks_i == '0) ? (SAMP_W+1)'(1) : {1'b0, samp_ticks_i};
  assign cnt_hit  = ({1'b0, scnt_q} + (SAMP_W+1)'(1)) >= samp_min;

  always_comb begin
    case (trig_sel_i)
      TRIG_SW:  trig_fire = samp_clr_i;
      TRIG_EXT: trig_fire = trig_rise[0];
      TRIG_TMR: trig_fire = trig_rise[1];
      TRIG_CNT: trig_fire = tick && cnt_hit;
      default:  trig_fire = 1'b0;
    endcase
  end

  always_comb begin
    state_d    = state_q;
    conv_start = 1'b0;
    if (!en_i) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_IDLE: if (samp_set_i || auto_samp_i) state_d = ST_SAMP;
        ST_SAMP: begin
          if (trig_fire) begin
            state_d    = ST_CONV;
            conv_start = 1'b1;
          end else if (samp_clr_i) begin
            state_d = ST_IDLE;
          end
        end
        ST_CONV: if (sar_last) state_d = auto_samp_i ? ST_SAMP : ST_IDLE;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      scnt_q   <= '0;
      done_q   <= 1'b0;
      valid_q  <= 1'b0;
      result_q <= '0;
    end else begin
      state_q <= state_d;

      if (restart || !in_samp)              scnt_q <= '0;
      else if (tick && (scnt_q != '1))      scnt_q <= scnt_q + 1'b1;

      if (conv_start)      done_q <= 1'b0;
      else if (sar_last)   done_q <= 1'b1;
      else if (done_clr_i) done_q <= 1'b0;

      valid_q <= sar_last;
      if (sar_last) result_q <= sar_code;
    end
  end

  assign samp_o         = in_samp;
  assign dac_code_o     = sar_code;
  assign done_o         = done_q;
  assign result_valid_o = valid_q;
  assign result_o       = result_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_i,
  input logic       auto_samp_i,
  input logic [2:0] trig_sel_i,
  input logic       samp_o,
  input logic       conv_i,
  input logic       bit_stb_o,
  input logic       done_o,
  input logic       result_valid_o
);
  p_stb_in_conv_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_stb_o |-> (conv_i && !samp_o));

  p_valid_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |=> !result_valid_o);

  p_valid_sets_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> done_o);

  p_start_clears_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (conv_i && !$past(conv_i)) |-> !done_o);

  p_disable_idles_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!samp_o && !conv_i && !result_valid_o));

  p_reserved_no_conv_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (samp_o && (trig_sel_i != 3'b000) && (trig_sel_i != 3'b001) &&
     (trig_sel_i != 3'b010) && (trig_sel_i != 3'b111)) |=> !conv_i);

  p_auto_restart_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_valid_o |-> (samp_o == $past(auto_samp_i)));

  p_idle_not_conv_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!samp_o && !conv_i) |=> !conv_i);
endmodule

bind adc_seq_ctrl adc_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .en_i           (en_i),
  .auto_samp_i    (auto_samp_i),
  .trig_sel_i     (trig_sel_i),
  .samp_o         (samp_o),
  .conv_i         (in_conv),
  .bit_stb_o      (bit_stb_o),
  .done_o         (done_o),
  .result_valid_o (result_valid_o)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, auto_s = 0, samp_set = 0, samp_clr = 0, ext = 0, tmr = 0, done_clr = 0;
  logic [2:0] sel = 3'b000;
  logic [7:0] clk_div = 0;
  logic [4:0] samp_ticks = 0;
  logic cmp, samp, stb, done, valid;
  logic [9:0] dac_code, result;
  int ain = 0;

  assign cmp = (ain >= int'(dac_code));

  always #(CLK_P/2) clk = ~clk;

  adc_seq_ctrl dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .auto_samp_i(auto_s),
    .samp_set_i(samp_set), .samp_clr_i(samp_clr), .trig_sel_i(sel),
    .ext_trig_i(ext), .tmr_match_i(tmr), .clk_div_i(clk_div),
    .samp_ticks_i(samp_ticks), .done_clr_i(done_clr), .cmp_i(cmp),
    .samp_o(samp), .dac_code_o(dac_code), .bit_stb_o(stb), .done_o(done),
    .result_valid_o(valid), .result_o(result)
  );

  int checks = 0, errs = 0;
  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 sampling, 2 converting; pc = cycles in phase
  int m_st, m_pc, m_res, per, nmin, nst;
  bit m_done, m_valid, re, rt, start, last, fire;
  bit [2:0] m_e, m_t;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pc = 0; m_res = 0; m_done = 0; m_valid = 0; m_e = 0; m_t = 0;
    end else begin
      per  = int'(clk_div) + 1;
      nmin = (samp_ticks == 0) ? 1 : int'(samp_ticks);
      re = m_e[1] & ~m_e[2];
      rt = m_t[1] & ~m_t[2];
      m_e = {m_e[1:0], ext};
      m_t = {m_t[1:0], tmr};
      nst = m_st; start = 0; last = 0;
      if (!en) nst = 0;
      else if (m_st == 0) begin
        if (samp_set || auto_s) nst = 1;
      end else if (m_st == 1) begin
        fire = (sel == 3'b000 && samp_clr) || (sel == 3'b001 && re) ||
               (sel == 3'b010 && rt) || (sel == 3'b111 && (m_pc + 1 == nmin * per));
        if (fire) begin nst = 2; start = 1; end
        else if (samp_clr) nst = 0;
      end else begin
        if (m_pc + 1 == 12 * per) begin last = 1; nst = auto_s ? 1 : 0; end
      end
      if (start) m_done = 0;
      else if (last) m_done = 1;
      else if (done_clr) m_done = 0;
      m_valid = last;
      if (last) m_res = ain;
      m_pc = (nst != m_st) ? 0 : m_pc + 1;
      m_st = nst;
    end
  end

  int cyc = 0, n_valid = 0, n_stb = 0, t_rise = 0, t_fall = 0, t_valid = 0, last_res = 0;
  bit p_samp = 0, e_stb;

  always @(posedge clk) begin
    #(CLK_P/4);
    cyc++;
    if (rst_n) begin
      per   = int'(clk_div) + 1;
      e_stb = (m_st == 2) && en && ((m_pc + 1) % per == 0) && ((m_pc + 1) / per <= 10);
      chk(samp == (m_st == 1), "R8", "samp_o vs model", int'(samp), int'(m_st == 1));
      chk(done == m_done, "R9", "done_o vs model", int'(done), int'(m_done));
      chk(valid == m_valid, "R2", "result_valid_o vs model", int'(valid), int'(m_valid));
      chk(stb == e_stb, "R3", "bit_stb_o vs model", int'(stb), int'(e_stb));
      if (valid && m_valid) chk(int'(result) == m_res, "R3", "result_o vs model", int'(result), m_res);
      if (samp && !p_samp) t_rise = cyc;
      if (!samp && p_samp) t_fall = cyc;
      if (valid) begin n_valid++; t_valid = cyc; last_res = int'(result); end
      if (stb) n_stb++;
      p_samp = samp;
    end
  end

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: samp_set = 1;
      1: samp_clr = 1;
      default: done_clr = 1;
    endcase
    @(negedge clk);
    samp_set = 0; samp_clr = 0; done_clr = 0;
  endtask

  task automatic conv_manual(input int a, input int div);
    int nv, ns, c0;
    sel = 3'b000; auto_s = 0; clk_div = 8'(div); ain = a;
    pulse(0); cyc_n(3);
    nv = n_valid; ns = n_stb;
    @(negedge clk); samp_clr = 1; c0 = cyc;
    @(negedge clk); samp_clr = 0;
    cyc_n(12 * (div + 1) + 6);
    chk(n_valid == nv + 1, "R4", "one result after manual end", n_valid - nv, 1);
    chk(t_fall == c0 + 1, "R4", "sampling end cycle", t_fall, c0 + 1);
    chk(t_valid - t_fall == 12 * (div + 1), "R2", "conversion length", t_valid - t_fall, 12 * (div + 1));
    chk(last_res == a, "R3", "converted code", last_res, a);
    chk(n_stb - ns == 10, "R3", "bit strobes", n_stb - ns, 10);
    chk(done && !samp, "R9", "done and idle after result", int'(done), 1);
  endtask

  task automatic conv_edge(input int which, input int a);
    int nv, c0;
    sel = (which == 0) ? 3'b001 : 3'b010; auto_s = 0; clk_div = 0; ain = a;
    nv = n_valid;
    @(negedge clk); if (which == 0) ext = 1; else tmr = 1;
    cyc_n(4); ext = 0; tmr = 0;
    cyc_n(20);
    chk(!samp && n_valid == nv, "R5", "edge while idle ignored", n_valid - nv, 0);
    pulse(0); cyc_n(3);
    @(negedge clk); if (which == 0) ext = 1; else tmr = 1; c0 = cyc;
    cyc_n(3); ext = 0; tmr = 0;
    cyc_n(20);
    chk(t_fall == c0 + 3, "R5", "synchronized trigger latency", t_fall, c0 + 3);
    chk(n_valid == nv + 1 && last_res == a, "R5", "edge-triggered result", last_res, a);
  endtask

  task automatic conv_count(input int ticks, input int div);
    int nv;
    sel = 3'b111; auto_s = 0; clk_div = 8'(div); samp_ticks = 5'(ticks); ain = 455;
    nv = n_valid;
    pulse(0);
    cyc_n(20 * (div + 1) + (ticks + 2) * (div + 1));
    chk(t_fall - t_rise == ((ticks == 0) ? 1 : ticks) * (div + 1), "R6", "counted sample length",
        t_fall - t_rise, ((ticks == 0) ? 1 : ticks) * (div + 1));
    chk(n_valid == nv + 1, "R6", "counter-mode result", n_valid - nv, 1);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    int nv, k;
    cyc_n(3);
    rst_n = 1;
    chk(!samp && !done && !valid, "R1", "outputs after reset", int'({samp, done, valid}), 0);
    cyc_n(2);
    chk(!samp && !done && !valid, "R1", "outputs after first edges", int'({samp, done, valid}), 0);

    // R11: set while disabled ignored
    pulse(0); cyc_n(2);
    chk(!samp, "R11", "set while disabled", int'(samp), 0);
    en = 1; cyc_n(2);

    conv_manual(700, 0);
    conv_manual(0, 3);
    conv_manual(1023, 3);
    conv_manual(341, 1);
    conv_manual(682, 0);

    // R9: done clear during conversion does not disturb it
    clk_div = 1; ain = 99; nv = n_valid;
    pulse(0); cyc_n(3); pulse(1); cyc_n(5);
    chk(!done, "R9", "done cleared at conversion start", int'(done), 0);
    pulse(2); cyc_n(30);
    chk(n_valid == nv + 1 && last_res == 99 && done, "R9", "result after mid-conversion clear", last_res, 99);
    pulse(2); cyc_n(1);
    chk(!done, "R9", "software clear of done", int'(done), 0);

    // R11: set during conversion ignored
    clk_div = 0; ain = 100; nv = n_valid;
    pulse(0); cyc_n(2); pulse(1); cyc_n(3); pulse(0); cyc_n(20);
    chk(!samp && n_valid == nv + 1, "R11", "set during conversion ignored", int'(samp), 0);

    // R10: disable aborts
    clk_div = 2; ain = 800; nv = n_valid;
    pulse(0); cyc_n(2); pulse(1); cyc_n(10);
    @(negedge clk); en = 0; @(negedge clk); en = 1;
    cyc_n(50);
    chk(n_valid == nv, "R10", "no result from aborted conversion", n_valid - nv, 0);
    chk(!samp && !done, "R10", "idle and not done after abort", int'({samp, done}), 0);

    conv_edge(0, 512);
    conv_edge(1, 257);

    conv_count(3, 1);
    conv_count(0, 1);
    conv_count(31, 0);

    // R8: automatic loop, then stop it mid-conversion
    sel = 3'b111; clk_div = 0; samp_ticks = 2; ain = 321; nv = n_valid;
    @(negedge clk); auto_s = 1;
    cyc_n(60);
    chk(n_valid - nv >= 3, "R8", "free-running results", n_valid - nv, 4);
    chk(t_rise == t_valid, "R8", "sampling restarts with result", t_rise, t_valid);
    k = 0;
    while (samp && k < 30) begin @(negedge clk); k++; end
    auto_s = 0; nv = n_valid;
    cyc_n(30);
    chk(n_valid == nv + 1 && !samp, "R8", "conversion finishes then idles", n_valid - nv, 1);

    // R7: reserved code never converts; clear returns idle
    sel = 3'b011; nv = n_valid;
    pulse(0); cyc_n(60);
    chk(samp && n_valid == nv, "R7", "reserved code holds sampling", int'(samp), 1);
    pulse(1); cyc_n(3);
    chk(!samp && n_valid == nv, "R7", "clear ends sampling without result", n_valid - nv, 0);
    sel = 3'b001; nv = n_valid;
    pulse(0); cyc_n(2); pulse(1); cyc_n(20);
    chk(!samp && n_valid == nv, "R7", "clear in edge mode aborts sampling", n_valid - nv, 0);

    cyc_n(5);
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end
endmodule